// File: doc/BRIEF.md
# Power-Mode and Clock-Select Controller

This block decides which power state a small microcontroller core is in and which oscillator drives it. A stored control word holds a CPU-idle enable bit and a 2-bit source request. A request to a source that is running takes effect on the next cycle. A request to a source that is not yet running waits until that source reports ready. The block drives a source-select output and two registered clock enables, one for the CPU and one for the peripherals. The clock multiplexer and the gating cells sit outside this block.

The low-power states can only be entered through a sleep command strobe. At that moment the stored idle bit chooses the state. When the bit is set, the CPU clock stops and the peripherals keep running (Idle). When the bit is clear, both clocks stop (Sleep). A wake event brings the core back to the Run state on the active source. A 3-bit status code reports which of the seven modes the block is in.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in Run on the primary source: `clk_src_sel` = 00, `mode_code` = 1, and both clock enables are high.
- R2: The stored request value 00 selects the primary source, 01 selects the secondary source, and 10 or 11 select the internal source. `clk_src_sel` reports the primary source as 00, the secondary as 01 and the internal as 10.
- R3: A control write at clock edge k with the requested source ready changes `clk_src_sel` at edge k+1.
- R4: While the requested source's ready flag is low, `clk_src_sel` keeps the current source. It changes on the first edge at which that flag is sampled high.
- R5: In every Run mode both `cpu_clk_en` and `per_clk_en` are high.
- R6: A sleep command in Run with the stored idle bit at 1 enters Idle on the active source. In Idle, `cpu_clk_en` = 0 and `per_clk_en` = 1.
- R7: A sleep command in Run with the stored idle bit at 0 enters Sleep. In Sleep, both enables are 0.
- R8: Only the sleep command leaves Run. Control writes, including ones that set the idle bit, do not. A sleep command in Idle or Sleep has no effect.
- R9: A wake event in Idle or Sleep returns the block to Run on the next edge, with `cpu_clk_en` high again. A wake event in Run has no effect.
- R10: `mode_code` is 0 for Sleep, 1/2/3 for Run on the primary/secondary/internal source, and 4/5/6 for Idle on those sources. The value 7 never appears.
- R11: Both enables and the mode change on the clock edge that samples the command, and they hold their value for at least one full cycle.
- R12: The sleep command uses the idle bit already stored. A control write on the same edge affects only later commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_idle_en | input | 1 | Idle bit to be written |
| cfg_src_req | input | 2 | Source request to be written |
| sleep_cmd | input | 1 | Sleep command strobe |
| wake_evt | input | 1 | Wake event |
| pri_rdy | input | 1 | Primary source running |
| sec_rdy | input | 1 | Secondary source running |
| int_rdy | input | 1 | Internal source running |
| clk_src_sel | output | 2 | Active source selection |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mode_code | output | 3 | Current mode code |

## Verification
The hardest case to reach is a control write that lands on the same edge as a sleep command, because the old and the new idle bit then lead to different states. The stimulus first stores idle = 1. It then drives the write of idle = 0 and the sleep strobe on the same falling edge and expects Idle. After a wake, a second sleep command must give full Sleep. A further case withdraws the secondary ready flag before its request. The flag stays low for several cycles, and the stimulus raises it at a known edge, so both the wait and the one-edge switch can be observed.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int SRC_W   = 2;
  localparam int NUM_SRC = 3;
  localparam int CODE_W  = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_INT = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_SLEEP = 2'd2
  } pstate_e;

  function automatic src_e decode_req(input logic [SRC_W-1:0] req);
    src_e s;
    if (req[SRC_W-1])  s = SRC_INT;
    else if (req[0])   s = SRC_SEC;
    else               s = SRC_PRI;
    return s;
  endfunction

  function automatic logic [CODE_W-1:0] encode_mode(input pstate_e st, input src_e src);
    logic [CODE_W-1:0] c;
    case (st)
      PM_RUN:  c = CODE_W'(1) + CODE_W'(src);
      PM_IDLE: c = CODE_W'(4) + CODE_W'(src);
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pmc_cfg_reg.sv
module pmc_cfg_reg
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             idle_in,
  input  logic [SRC_W-1:0] req_in,
  output logic             idle_q,
  output logic [SRC_W-1:0] req_q
);
  logic             idle_d;
  logic [SRC_W-1:0] req_d;

  always_comb begin
    idle_d = idle_q;
    req_d  = req_q;
    if (we) begin
      idle_d = idle_in;
      req_d  = req_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b0;
      req_q  <= '0;
    end else begin
      idle_q <= idle_d;
      req_q  <= req_d;
    end
  end
endmodule

// File: rtl/pmc_src_arb.sv
module pmc_src_arb
  import pmc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  src_e               req_src,
  input  logic [NUM_SRC-1:0] rdy,
  output src_e               act_src
);
  src_e act_d;
  logic switch_ok;

  always_comb begin
    switch_ok = (req_src != act_src) && rdy[req_src];
    act_d     = switch_ok ? req_src : act_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_src <= SRC_PRI;
    else        act_src <= act_d;
  end
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sleep_cmd,
  input  logic    wake_evt,
  input  logic    idle_bit,
  output pstate_e st_q,
  output logic    cpu_en_q,
  output logic    per_en_q
);
  pstate_e st_d;
  logic    cpu_en_d;
  logic    per_en_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      PM_RUN:            if (sleep_cmd) st_d = idle_bit ? PM_IDLE : PM_SLEEP;
      PM_IDLE, PM_SLEEP: if (wake_evt)  st_d = PM_RUN;
      default:           st_d = PM_RUN;
    endcase
    cpu_en_d = (st_d == PM_RUN);
    per_en_d = (st_d != PM_SLEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PM_RUN;
      cpu_en_q <= 1'b1;
      per_en_q <= 1'b1;
    end else begin
      st_q     <= st_d;
      cpu_en_q <= cpu_en_d;
      per_en_q <= per_en_d;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_idle_en,
  input  logic [SRC_W-1:0]  cfg_src_req,
  input  logic              sleep_cmd,
  input  logic              wake_evt,
  input  logic              pri_rdy,
  input  logic              sec_rdy,
  input  logic              int_rdy,
  output logic [SRC_W-1:0]  clk_src_sel,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic [CODE_W-1:0] mode_code
);
  logic               idle_q;
  logic [SRC_W-1:0]   req_q;
  logic [NUM_SRC-1:0] rdy_vec;
  src_e               req_src;
  src_e               act_src;
  pstate_e            st_q;

  assign rdy_vec = {int_rdy, sec_rdy, pri_rdy};
  assign req_src = decode_req(req_q);

  pmc_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .idle_in (cfg_idle_en),
    .req_in  (cfg_src_req),
    .idle_q  (idle_q),
    .req_q   (req_q)
  );

  pmc_src_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_src (req_src),
    .rdy     (rdy_vec),
    .act_src (act_src)
  );

  pmc_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_cmd (sleep_cmd),
    .wake_evt  (wake_evt),
    .idle_bit  (idle_q),
    .st_q      (st_q),
    .cpu_en_q  (cpu_clk_en),
    .per_en_q  (per_clk_en)
  );

  assign clk_src_sel = act_src;
  assign mode_code   = encode_mode(st_q, act_src);
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_cmd,
  input logic       wake_evt,
  input logic [2:0] rdy_vec,
  input logic       idle_q,
  input logic [1:0] clk_src_sel,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic [2:0] mode_code
);
  logic       in_run;
  logic       in_idle;
  logic [2:0] rdy_d;

  assign in_run  = (mode_code >= 3'd1) && (mode_code <= 3'd3);
  assign in_idle = (mode_code >= 3'd4) && (mode_code <= 3'd6);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_d <= '0;
    else        rdy_d <= rdy_vec;
  end

  AST_RUN_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |-> (cpu_clk_en && per_clk_en)); // R5
  AST_IDLE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> (!cpu_clk_en && per_clk_en)); // R6
  AST_SLEEP_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd0) |-> (!cpu_clk_en && !per_clk_en)); // R7
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code != 3'd7); // R10
  AST_SWITCH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src_sel != $past(clk_src_sel)) |-> rdy_d[clk_src_sel]); // R4
  AST_LEAVE_RUN_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_run) && !in_run) |-> $past(sleep_cmd)); // R8
  AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(in_run) && $past(wake_evt)) |-> in_run); // R9
  AST_IDLE_BIT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_run) && $past(sleep_cmd)) |-> ((mode_code == 3'd0) == !$past(idle_q))); // R12
endmodule

bind pwr_mode_ctrl pmc_checker u_pmc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_cmd   (sleep_cmd),
  .wake_evt    (wake_evt),
  .rdy_vec     (rdy_vec),
  .idle_q      (idle_q),
  .clk_src_sel (clk_src_sel),
  .cpu_clk_en  (cpu_clk_en),
  .per_clk_en  (per_clk_en),
  .mode_code   (mode_code)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  logic       clk;
  logic       rst_n;
  logic       cfg_we, cfg_idle_en;
  logic [1:0] cfg_src_req;
  logic       sleep_cmd, wake_evt;
  logic       pri_rdy, sec_rdy, int_rdy;
  logic [1:0] clk_src_sel;
  logic       cpu_clk_en, per_clk_en;
  logic [2:0] mode_code;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idle_en(cfg_idle_en),
    .cfg_src_req(cfg_src_req), .sleep_cmd(sleep_cmd), .wake_evt(wake_evt),
    .pri_rdy(pri_rdy), .sec_rdy(sec_rdy), .int_rdy(int_rdy),
    .clk_src_sel(clk_src_sel), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .mode_code(mode_code)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic expect_state(input string tag, input int mode, input int src,
                              input int cpu, input int per);
    check({tag, " mode"}, int'(mode_code), mode);
    check({tag, " src"},  int'(clk_src_sel), src);
    check({tag, " cpu"},  int'(cpu_clk_en), cpu);
    check({tag, " per"},  int'(per_clk_en), per);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic idle, input logic [1:0] req);
    cfg_we = 1'b1; cfg_idle_en = idle; cfg_src_req = req;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_sleep();
    sleep_cmd = 1'b1; step(); sleep_cmd = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_evt = 1'b1; step(); wake_evt = 1'b0;
  endtask

  task automatic t_reset();
    expect_state("R1 reset", 1, 0, 1, 1);
  endtask

  task automatic t_switch();
    write_cfg(1'b0, 2'b01);
    check("R11 no switch on write edge", int'(clk_src_sel), 0);
    step();
    expect_state("R3 R2 secondary run", 2, 1, 1, 1);
    write_cfg(1'b0, 2'b11); step();
    expect_state("R2 req 11 internal", 3, 2, 1, 1);
    write_cfg(1'b0, 2'b10); step();
    expect_state("R2 req 10 internal", 3, 2, 1, 1);
    write_cfg(1'b0, 2'b00); step();
    expect_state("R2 R10 primary run", 1, 0, 1, 1);
  endtask

  task automatic t_not_ready();
    sec_rdy = 1'b0;
    write_cfg(1'b0, 2'b01);
    step(); step(); step();
    check("R4 hold while not ready", int'(clk_src_sel), 0);
    check("R4 mode while waiting", int'(mode_code), 1);
    sec_rdy = 1'b1;
    step();
    check("R4 switch once ready", int'(clk_src_sel), 1);
    write_cfg(1'b0, 2'b00); step();
    check("R4 back to primary", int'(clk_src_sel), 0);
  endtask

  task automatic t_idle();
    write_cfg(1'b1, 2'b00); step();
    expect_state("R8 idle bit write stays run", 1, 0, 1, 1);
    pulse_sleep();
    expect_state("R6 R11 idle primary", 4, 0, 0, 1);
    pulse_sleep();
    expect_state("R8 sleep cmd in idle ignored", 4, 0, 0, 1);
    pulse_wake();
    expect_state("R9 wake from idle", 1, 0, 1, 1);
    write_cfg(1'b1, 2'b10); step();
    pulse_sleep();
    expect_state("R10 idle internal", 6, 2, 0, 1);
    pulse_wake();
    expect_state("R9 wake to internal run", 3, 2, 1, 1);
  endtask

  task automatic t_sleep();
    write_cfg(1'b0, 2'b01); step();
    pulse_sleep();
    expect_state("R7 full sleep", 0, 1, 0, 0);
    pulse_sleep();
    expect_state("R8 sleep cmd in sleep ignored", 0, 1, 0, 0);
    step();
    check("R11 enables held in sleep", int'(per_clk_en), 0);
    pulse_wake();
    expect_state("R9 wake from sleep", 2, 1, 1, 1);
    pulse_wake();
    expect_state("R9 wake in run ignored", 2, 1, 1, 1);
  endtask

  task automatic t_same_edge();
    write_cfg(1'b1, 2'b01); step();
    cfg_we = 1'b1; cfg_idle_en = 1'b0; cfg_src_req = 2'b01; sleep_cmd = 1'b1;
    step();
    cfg_we = 1'b0; sleep_cmd = 1'b0;
    expect_state("R12 old idle bit used", 5, 1, 0, 1);
    pulse_wake();
    pulse_sleep();
    expect_state("R12 new idle bit later", 0, 1, 0, 0);
    pulse_wake();
    expect_state("R12 wake after", 2, 1, 1, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idle_en = 1'b0; cfg_src_req = 2'b00;
    sleep_cmd = 1'b0; wake_evt = 1'b0;
    pri_rdy = 1'b1; sec_rdy = 1'b1; int_rdy = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_switch();
    t_not_ready();
    t_idle();
    t_sleep();
    t_same_edge();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule